// File: doc/BRIEF.md
# Bus-Attached Unsigned Multiply/Divide Unit

This block is an arithmetic helper for a processor that has no multiply or divide instructions of its own. It sits on a narrow synchronous register bus. Software writes operand words into byte-wide registers. Writing the second operand starts a sequential engine, which computes an unsigned product or an unsigned quotient and remainder one bit per clock. Software may do other bus work while the engine runs. After a fixed number of cycles it reads the answer from result registers.

Multiplication takes two single-word operands and gives a double-word product in 8 cycles. Division takes a double-word dividend and a single-word divisor and gives a double-word quotient and a remainder in 16 cycles. The remainder lands in the same register pair that holds the product. The unit keeps the first operand of each operation, so a constant factor or dividend only needs writing once. The figures here use the default bus width of 8 bits.

Top module: `bus_muldiv`

## Requirements
- R1: After reset, the quotient pair (0x14 low, 0x15 high), the result pair (0x16 low, 0x17 high) and the status register (0x18) all read 0.
- R2: A write to offset 0x03 (multiplier) starts a multiplication by the value held at offset 0x02 (multiplicand). That value is kept across any number of operations until it is written again.
- R3: Eight cycles after the starting write edge, the result pair holds the full unsigned product. A multiplication leaves the quotient pair unchanged.
- R4: A write to offset 0x06 (divisor) starts a division of the dividend held at offsets 0x04 (low byte) and 0x05 (high byte). The dividend is kept until it is written again.
- R5: Sixteen cycles after the starting write edge, the quotient pair holds floor(dividend/divisor). The result pair holds the remainder: the low byte at 0x16 and 0 at 0x17.
- R6: A division by zero gives a quotient of 0xFFFF and a remainder equal to the low byte of the dividend.
- R7: Bit 0 of the status register (0x18) reads 1 from the cycle after a starting write until the result is complete, and 0 otherwise. Bits 7..1 always read 0.
- R8: A starting write that arrives while an operation is running abandons that operation. The new operation runs from step zero and takes its full latency from the new write.
- R9: Read data is 0 while the read strobe is low. Read data is also 0 for any offset other than 0x14 to 0x18, including the operand offsets. Writes to offsets other than 0x02 to 0x06 change nothing.
- R10: During a multiplication, after k of the 8 steps, the result pair reads multiplicand × (multiplier mod 2^k).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (5) | Register offset |
| bus_wdata | input | BUS_W (8) | Write data |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_re | input | 1 | Read strobe, enables read data |
| bus_rdata | output | BUS_W (8) | Combinational read data |

## Verification
The bound checker runs on every cycle and covers four things. It matches the busy bit against a cycle counter started by each starting write, which covers both latencies and the restart on abort. It compares the completed product, quotient and remainder against arithmetic on captured operands, including the divide-by-zero pattern. It confirms that the quotient holds still through a multiplication and that reads are silent with the strobe low. Three things are shown only by the bench's scenarios. The first is the step-by-step partial products seen through early reads. The second is that operand registers persist across long sweeps. The third is that writes to result and unmapped offsets have no effect.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_MUL  = 2'd1,
      OP_DIV  = 2'd2
   } md_op_e;

   // register offsets
   localparam int OFS_FACTOR   = 'h02;
   localparam int OFS_MULGO    = 'h03;
   localparam int OFS_NUM_LO   = 'h04;
   localparam int OFS_NUM_HI   = 'h05;
   localparam int OFS_DIVGO    = 'h06;
   localparam int OFS_QUO_LO   = 'h14;
   localparam int OFS_QUO_HI   = 'h15;
   localparam int OFS_RES_LO   = 'h16;
   localparam int OFS_RES_HI   = 'h17;
   localparam int OFS_STATUS   = 'h18;
   localparam int OFS_MAX      = OFS_STATUS;

endpackage

// File: rtl/muldiv_regfile.sv
module muldiv_regfile
   import muldiv_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 we,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [BUS_W-1:0]     wdata,
   output logic [BUS_W-1:0]     factor,
   output logic [2*BUS_W-1:0]   numer,
   output logic                 go_mul,
   output logic                 go_div
);

   localparam int DW = 2 * BUS_W;

   logic [BUS_W-1:0] factor_q;
   logic [BUS_W-1:0] num_lo_q;
   logic [BUS_W-1:0] num_hi_q;

   logic hit_factor, hit_lo, hit_hi;

   always_comb begin
      hit_factor = we && (addr == ADDR_W'(OFS_FACTOR));
      hit_lo     = we && (addr == ADDR_W'(OFS_NUM_LO));
      hit_hi     = we && (addr == ADDR_W'(OFS_NUM_HI));
      go_mul     = we && (addr == ADDR_W'(OFS_MULGO));
      go_div     = we && (addr == ADDR_W'(OFS_DIVGO));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         factor_q <= '0;
         num_lo_q <= '0;
         num_hi_q <= '0;
      end else begin
         if (hit_factor) factor_q <= wdata;
         if (hit_lo)     num_lo_q <= wdata;
         if (hit_hi)     num_hi_q <= wdata;
      end
   end

   assign factor = factor_q;
   assign numer  = DW'({num_hi_q, num_lo_q});

endmodule

// File: rtl/muldiv_engine.sv
module muldiv_engine
   import muldiv_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 go_mul,
   input  logic                 go_div,
   input  logic [BUS_W-1:0]     operand,
   input  logic [BUS_W-1:0]     factor,
   input  logic [2*BUS_W-1:0]   numer,
   output logic [2*BUS_W-1:0]   quo,
   output logic [2*BUS_W-1:0]   res,
   output logic                 busy
);

   localparam int W         = BUS_W;
   localparam int DW        = 2 * BUS_W;
   localparam int MUL_STEPS = W;
   localparam int DIV_STEPS = DW;
   localparam int CW        = $clog2(DIV_STEPS + 1);

   md_op_e          op_q;
   logic [CW-1:0]   cnt_q;
   logic [DW-1:0]   quo_q;
   logic [DW-1:0]   res_q;
   logic [DW-1:0]   mc_sh_q;
   logic [W-1:0]    mp_sh_q;
   logic [W-1:0]    dv_q;

   // one restoring-division step
   logic [W:0]      trial;
   logic [W:0]      diff;
   logic            take;
   logic [W-1:0]    rem_next;

   always_comb begin
      trial    = {res_q[W-1:0], quo_q[DW-1]};
      diff     = trial - {1'b0, dv_q};
      take     = (trial >= {1'b0, dv_q});
      rem_next = take ? diff[W-1:0] : trial[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q    <= OP_NONE;
         cnt_q   <= '0;
         quo_q   <= '0;
         res_q   <= '0;
         mc_sh_q <= '0;
         mp_sh_q <= '0;
         dv_q    <= '0;
      end else if (go_mul) begin
         op_q    <= OP_MUL;
         cnt_q   <= CW'(MUL_STEPS);
         res_q   <= '0;
         mc_sh_q <= DW'(factor);
         mp_sh_q <= operand;
      end else if (go_div) begin
         op_q    <= OP_DIV;
         cnt_q   <= CW'(DIV_STEPS);
         quo_q   <= numer;
         res_q   <= '0;
         dv_q    <= operand;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CW'(1);
         if (op_q == OP_MUL) begin
            if (mp_sh_q[0]) res_q <= res_q + mc_sh_q;
            mc_sh_q <= mc_sh_q << 1;
            mp_sh_q <= mp_sh_q >> 1;
         end else begin
            quo_q <= {quo_q[DW-2:0], take};
            res_q <= DW'(rem_next);
         end
      end
   end

   assign quo  = quo_q;
   assign res  = res_q;
   assign busy = (cnt_q != '0);

endmodule

// File: rtl/muldiv_rdmux.sv
module muldiv_rdmux
   import muldiv_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 5
) (
   input  logic                 re,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [2*BUS_W-1:0]   quo,
   input  logic [2*BUS_W-1:0]   res,
   input  logic                 busy,
   output logic [BUS_W-1:0]     rdata
);

   localparam int W = BUS_W;

   logic [W-1:0] sel;

   always_comb begin
      sel = '0;
      if (addr == ADDR_W'(OFS_QUO_LO))      sel = quo[W-1:0];
      else if (addr == ADDR_W'(OFS_QUO_HI)) sel = quo[2*W-1:W];
      else if (addr == ADDR_W'(OFS_RES_LO)) sel = res[W-1:0];
      else if (addr == ADDR_W'(OFS_RES_HI)) sel = res[2*W-1:W];
      else if (addr == ADDR_W'(OFS_STATUS)) sel = W'(busy);
      rdata = re ? sel : '0;
   end

endmodule

// File: rtl/bus_muldiv.sv
module bus_muldiv
   import muldiv_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   input  logic                 bus_we,
   input  logic                 bus_re,
   output logic [BUS_W-1:0]     bus_rdata
);

   localparam int DW = 2 * BUS_W;

   if (BUS_W < 2) begin : g_bad_width
      $error("bus_muldiv: BUS_W must be at least 2");
   end
   if ((1 << ADDR_W) <= OFS_MAX) begin : g_bad_addr
      $error("bus_muldiv: ADDR_W too small for the register map");
   end

   logic [BUS_W-1:0] factor_w;
   logic [DW-1:0]    numer_w;
   logic             go_mul_w;
   logic             go_div_w;
   logic [DW-1:0]    quo_w;
   logic [DW-1:0]    res_w;
   logic             busy_w;

   muldiv_regfile #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_we),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .factor (factor_w),
      .numer  (numer_w),
      .go_mul (go_mul_w),
      .go_div (go_div_w)
   );

   muldiv_engine #(.BUS_W(BUS_W)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_mul  (go_mul_w),
      .go_div  (go_div_w),
      .operand (bus_wdata),
      .factor  (factor_w),
      .numer   (numer_w),
      .quo     (quo_w),
      .res     (res_w),
      .busy    (busy_w)
   );

   muldiv_rdmux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_rdmux (
      .re    (bus_re),
      .addr  (bus_addr),
      .quo   (quo_w),
      .res   (res_w),
      .busy  (busy_w),
      .rdata (bus_rdata)
   );

endmodule

// File: rtl/bus_muldiv_chk.sv
module bus_muldiv_chk
   import muldiv_pkg::*;
#(
   parameter int BUS_W  = 8,
   parameter int ADDR_W = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   input  logic                 bus_we,
   input  logic                 bus_re,
   input  logic [BUS_W-1:0]     bus_rdata,
   input  logic [BUS_W-1:0]     factor,
   input  logic [2*BUS_W-1:0]   numer,
   input  logic [2*BUS_W-1:0]   quo,
   input  logic [2*BUS_W-1:0]   res,
   input  logic                 busy
);

   localparam int W  = BUS_W;
   localparam int DW = 2 * BUS_W;
   localparam int AW = $clog2(DW + 1);

   logic            st_mul, st_div, st_any;
   md_op_e          cop;
   logic [AW-1:0]   age;
   logic [W-1:0]    cap_a, cap_b;
   logic [DW-1:0]   cap_n;
   logic [AW-1:0]   lat;

   always_comb begin
      st_mul = bus_we && (bus_addr == ADDR_W'(OFS_MULGO));
      st_div = bus_we && (bus_addr == ADDR_W'(OFS_DIVGO));
      st_any = st_mul || st_div;
      lat    = (cop == OP_MUL) ? AW'(W) : AW'(DW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cop   <= OP_NONE;
         age   <= '0;
         cap_a <= '0;
         cap_b <= '0;
         cap_n <= '0;
      end else if (st_mul) begin
         cop   <= OP_MUL;
         age   <= '0;
         cap_a <= factor;
         cap_b <= bus_wdata;
      end else if (st_div) begin
         cop   <= OP_DIV;
         age   <= '0;
         cap_n <= numer;
         cap_b <= bus_wdata;
      end else if (age != AW'(DW)) begin
         age <= age + AW'(1);
      end
   end

   // R7
   start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_any |=> busy);

   // R8
   busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop != OP_NONE) |-> (busy == (age < lat)));

   // R1
   idle_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop == OP_NONE) |-> !busy);

   // R3
   product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop == OP_MUL && age >= AW'(W)) |-> (res == ({{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b})));

   // R3
   quo_held_in_mul_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop == OP_MUL) |-> $stable(quo));

   // R5
   quotient_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop == OP_DIV && age >= AW'(DW) && cap_b != '0)
      |-> (quo == cap_n / {{W{1'b0}}, cap_b} && res == cap_n % {{W{1'b0}}, cap_b}));

   // R6
   div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cop == OP_DIV && age >= AW'(DW) && cap_b == '0)
      |-> (quo == {DW{1'b1}} && res == {{W{1'b0}}, cap_n[W-1:0]}));

   // R9
   quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |-> (bus_rdata == '0));

endmodule

bind bus_muldiv bus_muldiv_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_rdata (bus_rdata),
   .factor    (factor_w),
   .numer     (numer_w),
   .quo       (quo_w),
   .res       (res_w),
   .busy      (busy_w)
);

// File: tb/bus_muldiv_test.sv
module bus_muldiv_test;

   localparam int CLK_PERIOD = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic       bus_we = 1'b0;
   logic       bus_re = 1'b0;
   logic [7:0] bus_rdata;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_muldiv uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr  = 5'(a);
      bus_wdata = 8'(d);
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   // combinational read in the low phase, no clock advance
   task automatic peek(input int a, output int v);
      bus_addr = 5'(a);
      bus_re   = 1'b1;
      #1;
      v = int'(bus_rdata);
      bus_re   = 1'b0;
   endtask

   task automatic peek16(input int a, output int v);
      int lo, hi;
      peek(a, lo);
      peek(a + 1, hi);
      v = (hi << 8) | lo;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int v, q, r, qprev;
      int a, b, n, exp_q, exp_r;
      int nums[5];
      nums[0] = 'hFFFF; nums[1] = 'h1234; nums[2] = 'h00FF;
      nums[3] = 'h8001; nums[4] = 'h0000;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      peek16('h14, v); check(v == 0, "R1 quotient", v, 0);
      peek16('h16, v); check(v == 0, "R1 result", v, 0);
      peek('h18, v);   check(v == 0, "R1 status", v, 0);

      // R10 / R7 partial products and busy timing
      wr('h02, 'hB7);
      peek16('h14, qprev);
      wr('h03, 'hD5);
      for (int k = 0; k <= 8; k++) begin
         peek('h18, v);
         check(v == (k < 8 ? 1 : 0), "R7 busy during multiply", v, (k < 8 ? 1 : 0));
         peek16('h16, v);
         exp_r = 'hB7 * ('hD5 & ((1 << k) - 1));
         check(v == exp_r, "R10 partial product", v, exp_r);
         if (k < 8) wait_cyc(1);
      end
      peek16('h14, v);
      check(v == qprev, "R3 quotient untouched by multiply", v, qprev);

      // R9 read strobe low and unmapped/operand offsets
      bus_addr = 5'h16; bus_re = 1'b0; #1;
      check(bus_rdata == 0, "R9 strobe low", int'(bus_rdata), 0);
      peek('h02, v); check(v == 0, "R9 operand offset reads zero", v, 0);
      peek('h1F, v); check(v == 0, "R9 unmapped offset", v, 0);

      // R9 writes to result/unmapped offsets ignored
      wr('h16, 'hAA);
      wr('h14, 'h55);
      wr('h07, 'h33);
      peek16('h16, v); check(v == 'hB7 * 'hD5, "R9 result unchanged by write", v, 'hB7 * 'hD5);
      peek16('h14, v); check(v == qprev, "R9 quotient unchanged by write", v, qprev);
      peek('h18, v);   check(v == 0, "R9 no start from stray write", v, 0);

      // R2 / R3 sweep: multiplicand written once per outer pass
      for (int ia = 0; ia < 16; ia++) begin
         a = ia * 17;
         wr('h02, a);
         for (int ib = 0; ib < 256; ib++) begin
            b = ib;
            wr('h03, b);
            wait_cyc(7);
            @(negedge clk);
            peek16('h16, v);
            check(v == a * b, "R2 R3 product", v, a * b);
         end
      end

      // R4 / R5 / R6 sweep: dividend written once per outer pass
      for (int in = 0; in < 5; in++) begin
         n = nums[in];
         wr('h04, n & 'hFF);
         wr('h05, (n >> 8) & 'hFF);
         for (int id = 0; id < 256; id++) begin
            wr('h06, id);
            wait_cyc(16);
            peek16('h14, q);
            peek16('h16, r);
            if (id == 0) begin
               check(q == 'hFFFF, "R6 zero divisor quotient", q, 'hFFFF);
               check(r == (n & 'hFF), "R6 zero divisor remainder", r, n & 'hFF);
            end else begin
               exp_q = n / id;
               exp_r = n % id;
               check(q == exp_q, "R4 R5 quotient", q, exp_q);
               check(r == exp_r, "R5 remainder", r, exp_r);
            end
         end
      end

      // R7 busy across a division
      wr('h04, 'h39); wr('h05, 'hC2);
      wr('h06, 'h0D);
      wait_cyc(15);
      peek('h18, v); check(v == 1, "R7 busy at step 15", v, 1);
      wait_cyc(1);
      peek('h18, v); check(v == 0, "R7 idle at step 16", v, 0);

      // R2 multiplicand still held after divisions (last written 255)
      wr('h03, 'h02);
      wait_cyc(8);
      peek16('h16, v); check(v == 255 * 2, "R2 multiplicand retained", v, 510);

      // R8 multiply restarted by a new multiplier
      wr('h02, 'h9C);
      wr('h03, 'hFF);
      wait_cyc(3);
      wr('h03, 'h21);
      wait_cyc(7);
      peek('h18, v); check(v == 1, "R8 restart keeps busy", v, 1);
      wait_cyc(1);
      peek('h18, v); check(v == 0, "R8 restart completes", v, 0);
      peek16('h16, v); check(v == 'h9C * 'h21, "R8 restarted product", v, 'h9C * 'h21);

      // R8 multiply aborted by a division; R4 dividend retained
      wr('h03, 'h77);
      wait_cyc(5);
      wr('h06, 'h0D);
      wait_cyc(15);
      peek('h18, v); check(v == 1, "R8 abort busy", v, 1);
      wait_cyc(1);
      peek16('h14, q); check(q == 'hC239 / 13, "R8 R4 quotient after abort", q, 'hC239 / 13);
      peek16('h16, r); check(r == 'hC239 % 13, "R8 remainder after abort", r, 'hC239 % 13);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule